// File: doc/BRIEF.md
# Exception Vector Priority Resolver

This block sits between the exception and interrupt request lines of a processor subsystem and the CPU's vector fetch. It watches three reset classes, an unimplemented-opcode trap, a software/debug vector request, a non-maskable interrupt line, a maskable interrupt line and a bank of device interrupt lines. It reports to the CPU whenever any unmasked request is pending. When the CPU strobes a vector request, the block picks the winning source by a fixed priority order and returns its 16-bit vector address.

Reset classes map to fixed absolute addresses. Every other vector is formed from a programmable 8-bit base, which gives the upper byte, and a fixed low-byte offset. Sometimes a request is seen and then withdrawn before the CPU asks for its vector. When that happens and no eligible request is left at the strobe, the block returns a dedicated spurious vector, so the CPU always receives a defined address.

Top module: `vec_resolver`

## Requirements
- R1: After synchronous reset, `vec_valid`, `int_pending` and `vec_addr` are all 0.
- R2: A vector request while `req_por` is high returns 0xFFFE, whatever other lines are active.
- R3: If `req_por` is low, `req_clkmon` returns 0xFFFC. If both of those are low, `req_cop` returns 0xFFFA.
- R4: With no reset line active, `req_trap` returns {base, 0xF8}, ahead of all lower sources.
- R5: With no higher line active, `req_swi` returns {base, 0xF6}, ahead of the two interrupt lines and the devices.
- R6: With no higher line active, `req_xirq` returns {base, 0xF4}, even when `imask` is 1.
- R7: With no higher line active and `imask` 0, `req_irq` returns {base, 0xF2}. When `imask` is 1, `req_irq` is ignored.
- R8: Device line n (bit n of `dev_req`) returns {base, 0xF0 - 2n}. Among several device lines the lowest index wins. Device lines lose to `req_irq` and are ignored while `imask` is 1.
- R9: If no eligible request is active at the strobe, the result is the spurious vector {base, 0x10}.
- R10: `vec_valid` is a one-cycle pulse in the cycle after each `vec_req` cycle. `vec_addr` then holds its value until the next strobe.
- R11: `int_pending` is high one cycle after any eligible request is present (resets, trap, swi, xirq, or irq/device lines with `imask` 0), and low one cycle after none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_por | input | 1 | Pin/power-on/low-voltage/illegal-address reset class |
| req_clkmon | input | 1 | Clock monitor reset class |
| req_cop | input | 1 | Watchdog reset class |
| req_trap | input | 1 | Unimplemented opcode trap |
| req_swi | input | 1 | Software interrupt or debug vector request |
| req_xirq | input | 1 | Non-maskable interrupt request |
| req_irq | input | 1 | Maskable interrupt request |
| dev_req | input | NUM_DEV | Device maskable interrupt lines, bit 0 highest |
| imask | input | 1 | Maskable-interrupt mask, 1 = masked |
| vec_base | input | 8 | Vector base, upper address byte |
| vec_req | input | 1 | CPU vector request strobe |
| int_pending | output | 1 | Registered: an eligible request is pending |
| vec_addr | output | 16 | Registered resolved vector address |
| vec_valid | output | 1 | One-cycle pulse marking a new vec_addr |

## Verification
Request lines are sampled in the strobe cycle, so each resolved address and its valid pulse appear exactly one clock edge after that strobe. The driver pushes the expected address when it raises the strobe. The monitor pops and compares on the falling edge after the next rising edge, and it flags any valid pulse that arrives with nothing expected. `int_pending` has the same one-edge latency and is checked on the falling edge that follows the input change. The hold behaviour is checked by changing inputs without a strobe and reading `vec_addr` one edge later.

// File: rtl/vec_pkg.sv
package vec_pkg;
  typedef enum logic [3:0] {
    SRC_POR, SRC_CLKMON, SRC_COP, SRC_TRAP, SRC_SWI,
    SRC_XIRQ, SRC_IRQ, SRC_DEV, SRC_SPUR
  } src_e;

  localparam logic [15:0] ABS_POR    = 16'hFFFE;
  localparam logic [15:0] ABS_CLKMON = 16'hFFFC;
  localparam logic [15:0] ABS_COP    = 16'hFFFA;

  localparam logic [7:0] OFS_TRAP  = 8'hF8;
  localparam logic [7:0] OFS_SWI   = 8'hF6;
  localparam logic [7:0] OFS_XIRQ  = 8'hF4;
  localparam logic [7:0] OFS_IRQ   = 8'hF2;
  localparam logic [7:0] OFS_DEV0  = 8'hF0;
  localparam logic [7:0] OFS_DEVLO = 8'h12;
  localparam logic [7:0] OFS_SPUR  = 8'h10;

  localparam int MAX_DEV_SLOTS = (int'(OFS_DEV0) - int'(OFS_DEVLO)) / 2 + 1;
endpackage

// File: rtl/dev_prio_enc.sv
module dev_prio_enc
  import vec_pkg::*;
#(
  parameter int NUM_DEV = 64,
  parameter int IDX_W   = 6
) (
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               imask,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  localparam int USED = (NUM_DEV < MAX_DEV_SLOTS) ? NUM_DEV : MAX_DEV_SLOTS;

  logic [NUM_DEV-1:0] live;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_line
    if (g < USED) begin : g_on
      assign live[g] = dev_req[g] & ~imask;
    end else begin : g_off
      assign live[g] = 1'b0;
    end
  end

  // Lowest index = highest vector address = highest priority.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (live[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/src_arbiter.sv
module src_arbiter
  import vec_pkg::*;
(
  input  logic req_por,
  input  logic req_clkmon,
  input  logic req_cop,
  input  logic req_trap,
  input  logic req_swi,
  input  logic req_xirq,
  input  logic req_irq,
  input  logic imask,
  input  logic dev_hit,
  output src_e sel,
  output logic any
);
  always_comb begin
    if      (req_por)              sel = SRC_POR;
    else if (req_clkmon)           sel = SRC_CLKMON;
    else if (req_cop)              sel = SRC_COP;
    else if (req_trap)             sel = SRC_TRAP;
    else if (req_swi)              sel = SRC_SWI;
    else if (req_xirq)             sel = SRC_XIRQ;
    else if (req_irq && !imask)    sel = SRC_IRQ;
    else if (dev_hit)              sel = SRC_DEV;
    else                           sel = SRC_SPUR;
    any = (sel != SRC_SPUR);
  end
endmodule

// File: rtl/vec_former.sv
module vec_former
  import vec_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  src_e             sel,
  input  logic [7:0]       base,
  input  logic [IDX_W-1:0] dev_idx,
  output logic [15:0]      addr
);
  logic [7:0] dev_ofs;

  always_comb begin
    dev_ofs = OFS_DEV0 - 8'({dev_idx, 1'b0});
    unique case (sel)
      SRC_POR:    addr = ABS_POR;
      SRC_CLKMON: addr = ABS_CLKMON;
      SRC_COP:    addr = ABS_COP;
      SRC_TRAP:   addr = {base, OFS_TRAP};
      SRC_SWI:    addr = {base, OFS_SWI};
      SRC_XIRQ:   addr = {base, OFS_XIRQ};
      SRC_IRQ:    addr = {base, OFS_IRQ};
      SRC_DEV:    addr = {base, dev_ofs};
      default:    addr = {base, OFS_SPUR};
    endcase
  end
endmodule

// File: rtl/vec_resolver.sv
module vec_resolver
  import vec_pkg::*;
#(
  parameter int NUM_DEV = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_por,
  input  logic               req_clkmon,
  input  logic               req_cop,
  input  logic               req_trap,
  input  logic               req_swi,
  input  logic               req_xirq,
  input  logic               req_irq,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               imask,
  input  logic [7:0]         vec_base,
  input  logic               vec_req,
  output logic               int_pending,
  output logic [15:0]        vec_addr,
  output logic               vec_valid
);
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             dev_hit;
  logic [IDX_W-1:0] dev_idx;
  src_e             sel;
  logic             any_live;
  logic [15:0]      next_addr;

  dev_prio_enc #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_enc (
    .dev_req(dev_req), .imask(imask), .hit(dev_hit), .idx(dev_idx)
  );

  src_arbiter u_arb (
    .req_por(req_por), .req_clkmon(req_clkmon), .req_cop(req_cop),
    .req_trap(req_trap), .req_swi(req_swi), .req_xirq(req_xirq),
    .req_irq(req_irq), .imask(imask), .dev_hit(dev_hit),
    .sel(sel), .any(any_live)
  );

  vec_former #(.IDX_W(IDX_W)) u_form (
    .sel(sel), .base(vec_base), .dev_idx(dev_idx), .addr(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_pending <= 1'b0;
      vec_valid   <= 1'b0;
      vec_addr    <= '0;
    end else begin
      int_pending <= any_live;
      vec_valid   <= vec_req;
      if (vec_req) vec_addr <= next_addr;
    end
  end

  // R10: valid pulse follows each strobe by one edge, and only then
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> vec_valid);
  p_valid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !vec_req |=> !vec_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !vec_req |=> $stable(vec_addr));
  // R2: top reset class always wins
  p_por_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (vec_req && req_por) |=> vec_addr == ABS_POR);
  // R6: non-maskable line ignores imask
  p_xirq_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
    (vec_req && req_xirq && !req_por && !req_clkmon && !req_cop &&
     !req_trap && !req_swi) |=> vec_addr[7:0] == OFS_XIRQ);
  // R9: nothing active gives the spurious vector
  p_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !req_por && !req_clkmon && !req_cop && !req_trap &&
     !req_swi && !req_xirq && (imask || (!req_irq && dev_req == '0)))
    |=> vec_addr == {$past(vec_base), OFS_SPUR});
  // R8: encoder only reports a line that is really requesting
  p_dev_hit_real_r8: assert property (@(posedge clk) disable iff (rst)
    dev_hit |-> (dev_req[dev_idx] && !imask));
  // R11: pending tracks the non-maskable line
  p_pend_xirq_r11: assert property (@(posedge clk) disable iff (rst)
    req_xirq |=> int_pending);
endmodule

// File: tb/sim_vec_resolver.sv
module sim_vec_resolver;
  localparam int NUM_DEV = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_por = 0, req_clkmon = 0, req_cop = 0, req_trap = 0, req_swi = 0;
  logic req_xirq = 0, req_irq = 0, imask = 0, vec_req = 0;
  logic [NUM_DEV-1:0] dev_req = '0;
  logic [7:0] vec_base = 8'h00;
  logic int_pending, vec_valid;
  logic [15:0] vec_addr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  vec_resolver #(.NUM_DEV(NUM_DEV)) u0 (
    .clk(clk), .rst(rst), .req_por(req_por), .req_clkmon(req_clkmon),
    .req_cop(req_cop), .req_trap(req_trap), .req_swi(req_swi),
    .req_xirq(req_xirq), .req_irq(req_irq), .dev_req(dev_req),
    .imask(imask), .vec_base(vec_base), .vec_req(vec_req),
    .int_pending(int_pending), .vec_addr(vec_addr), .vec_valid(vec_valid)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference priority model written from the requirements.
  function automatic logic [15:0] model();
    if (req_por)    return 16'hFFFE;
    if (req_clkmon) return 16'hFFFC;
    if (req_cop)    return 16'hFFFA;
    if (req_trap)   return {vec_base, 8'hF8};
    if (req_swi)    return {vec_base, 8'hF6};
    if (req_xirq)   return {vec_base, 8'hF4};
    if (!imask) begin
      if (req_irq) return {vec_base, 8'hF2};
      for (int n = 0; n < NUM_DEV; n++)
        if (dev_req[n]) return {vec_base, 8'(240 - 2 * n)};
    end
    return {vec_base, 8'h10};
  endfunction

  task automatic clear_reqs();
    {req_por, req_clkmon, req_cop, req_trap, req_swi, req_xirq, req_irq} = '0;
    dev_req = '0;
  endtask

  // Driver: inputs are already set; strobe and push the expectation.
  task automatic strobe(string tag);
    @(negedge clk);
    vec_req = 1'b1;
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
    vec_req = 1'b0;
    clear_reqs();
  endtask

  // Monitor: compare each valid result against the queue.
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R10: actual unexpected valid expected none");
      end else begin
        check(tag_q.pop_front(), vec_addr, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 valid", {15'd0, vec_valid}, 16'd0);
    check("R1 pending", {15'd0, int_pending}, 16'd0);
    check("R1 addr", vec_addr, 16'd0);

    vec_base = 8'h3C;
    req_por = 1; req_clkmon = 1; req_trap = 1; dev_req[0] = 1; strobe("R2 por");
    req_clkmon = 1; req_cop = 1; req_swi = 1; strobe("R3 clkmon");
    req_cop = 1; req_trap = 1; req_xirq = 1; strobe("R3 cop");
    req_trap = 1; req_swi = 1; req_irq = 1; strobe("R4 trap");
    req_swi = 1; req_xirq = 1; dev_req[3] = 1; strobe("R5 swi");
    imask = 1; req_xirq = 1; req_irq = 1; strobe("R6 xirq masked");
    imask = 0; req_irq = 1; dev_req[0] = 1; strobe("R7 irq");
    imask = 1; req_irq = 1; strobe("R7 irq masked");
    imask = 0;
    vec_base = 8'hA5;
    dev_req[0] = 1; strobe("R8 dev0");
    dev_req[63] = 1; strobe("R8 dev63");
    dev_req[10] = 1; dev_req[5] = 1; dev_req[40] = 1; strobe("R8 dev lowest");
    imask = 1; dev_req[7] = 1; strobe("R8 dev masked");
    imask = 0;
    vec_base = 8'h01; strobe("R9 spurious");
    // back-to-back strobes
    @(negedge clk);
    req_swi = 1; vec_req = 1; exp_q.push_back(model()); tag_q.push_back("R10 b2b a");
    @(negedge clk);
    req_swi = 0; req_cop = 1; exp_q.push_back(model()); tag_q.push_back("R10 b2b b");
    @(negedge clk);
    vec_req = 0; clear_reqs();
    @(negedge clk);
    // R10: hold without strobe
    held = vec_addr;
    req_por = 1; vec_base = 8'hEE;
    @(negedge clk);
    check("R10 hold", vec_addr, held);
    check("R10 no valid", {15'd0, vec_valid}, 16'd0);
    clear_reqs();
    // R11: pending behaviour
    @(negedge clk);
    check("R11 idle low", {15'd0, int_pending}, 16'd0);
    imask = 1; req_irq = 1; dev_req[2] = 1;
    @(negedge clk);
    check("R11 masked low", {15'd0, int_pending}, 16'd0);
    imask = 0;
    @(negedge clk);
    check("R11 unmasked high", {15'd0, int_pending}, 16'd1);
    clear_reqs(); imask = 1; req_xirq = 1;
    @(negedge clk);
    check("R11 xirq high", {15'd0, int_pending}, 16'd1);
    clear_reqs();
    @(negedge clk);
    check("R11 drop low", {15'd0, int_pending}, 16'd0);
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R10: actual %0d results missing expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule